// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words and returns their product as a 32-bit word of the same format. The layout is: sign in bit 31, an 8-bit exponent with a bias of 127 in bits 30:23, and a 23-bit fraction in bits 22:0. Normal numbers carry an implied leading one. A caller presents both operands with `in_valid` high for one cycle. Exactly one clock later than a registered single-stage path would give, the product appears with `out_valid`, together with flags that report exponent overflow and underflow. A new operation may start every cycle.

Internally the first pipeline stage classifies both operands and forms the sign by exclusive-or. It adds the two biased exponents and removes one bias, and it multiplies the two 24-bit significands into a 48-bit product. The second stage shifts that product right by at most one position, rounds to nearest with ties to even, checks the exponent against the legal biased range, and packs the word.

Subnormal inputs are treated as zero, and results too small to be normal are flushed to zero. Only the nearest-even rounding mode exists, and every NaN result is a single quiet pattern.

Top module: `sp_fmul`

## Requirements
- R1: For every result that is not a NaN, bit 31 of `result` equals the exclusive-or of bit 31 of the two operands.
- R2: For two normal operands whose product needs no normalization shift, the biased result exponent is the sum of the operand exponent fields minus 127. For example, 0x3F000000 (0.5) times 0xBEE00000 (-0.4375) gives 0xBE600000 (-0.21875, exponent field 124).
- R3: When the significand product is 2 or more, it is shifted right one place and the exponent is incremented. For example, 0x3FC00000 times 0x3FC00000 gives 0x40100000.
- R4: The fraction is rounded to nearest, with ties to the even fraction. If rounding carries out of the fraction, the exponent is incremented. 0x3F800001 times 0x3FC00000 gives 0x3FC00002, and 0x3F800003 times 0x3FC00000 gives 0x3FC00004.
- R5: When the final biased exponent of a product of two normal operands exceeds 254, `result` is an infinity of the computed sign (exponent field all ones, fraction zero) and `ovf` is 1. An exponent of exactly 254 is kept and no flag is raised.
- R6: When the final biased exponent is below 1, `result` is a zero of the computed sign and `unf` is 1. An exponent of exactly 1 is kept and no flag is raised.
- R7: An operand with exponent field 0 counts as zero, whatever its fraction. Zero times a finite value gives a zero of the computed sign, with both flags 0.
- R8: An infinity (exponent all ones, fraction zero) times a nonzero value or another infinity gives an infinity of the computed sign, with both flags 0.
- R9: If either operand is a NaN (exponent all ones, fraction nonzero), or the operation is zero times infinity, `result` is 0x7FC00000 and both flags are 0.
- R10: `out_valid` is high for exactly one cycle per accepted operation. It rises after the second rising clock edge counted from the edge that samples `in_valid` high. Results leave in the order the operations arrived, including back-to-back operations.
- R11: While `rst` is high at a rising edge, `out_valid`, `ovf` and `unf` are cleared. Operands presented during reset produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are present this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | `result` and flags are valid this cycle |
| result | output | 32 | Rounded product |
| ovf | output | 1 | Exponent overflow, result forced to infinity |
| unf | output | 1 | Exponent underflow, result flushed to zero |

## Verification
The bench builds the block with its default widths: an 8-bit exponent and a 23-bit fraction. With those widths, the whole legal exponent range is reached from single operand pairs. Products near 2^128 and 2^-126 expose both the overflow and underflow edges as well as the last legal exponents on each side. The expected values come from an exact double-width product that is then rounded to 24 bits, so ties, round-up carries and the normalization shift are compared against a model with no significand datapath of its own. Directed corner vectors for signed zeros, infinities and NaNs are mixed with a randomized sweep. The sweep includes back-to-back issue and idle gaps, so the fixed latency and ordering are exercised along with the arithmetic.

// File: rtl/sp_fmul_pkg.sv
package sp_fmul_pkg;

  // Operand class after unpacking
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fp_class_e;

  // What the output stage must produce
  typedef enum logic [1:0] {
    RK_NUM  = 2'd0,
    RK_ZERO = 2'd1,
    RK_INF  = 2'd2,
    RK_NAN  = 2'd3
  } res_kind_e;

  // Special-value resolution (R7, R8, R9)
  function automatic res_kind_e pick_kind(input fp_class_e ca, input fp_class_e cb);
    res_kind_e k;
    if (ca == CLS_NAN || cb == CLS_NAN)
      k = RK_NAN;
    else if ((ca == CLS_INF && cb == CLS_ZERO) || (ca == CLS_ZERO && cb == CLS_INF))
      k = RK_NAN;
    else if (ca == CLS_INF || cb == CLS_INF)
      k = RK_INF;
    else if (ca == CLS_ZERO || cb == CLS_ZERO)
      k = RK_ZERO;
    else
      k = RK_NUM;
    return k;
  endfunction

endpackage

// File: rtl/sp_fmul_unpack.sv
module sp_fmul_unpack
  import sp_fmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output logic                  sign,
  output logic [EXP_W-1:0]      bexp,
  output logic [FRAC_W:0]       sig,
  output fp_class_e             cls
);

  localparam int W = EXP_W + FRAC_W + 1;

  logic [FRAC_W-1:0] frac;

  assign sign = word[W-1];
  assign bexp = word[W-2 -: EXP_W];
  assign frac = word[FRAC_W-1:0];
  // implied leading one; subnormals are classed as zero so it is never wrong
  assign sig  = {1'b1, frac};

  always_comb begin
    if (bexp == '0)
      cls = CLS_ZERO;
    else if (bexp == '1)
      cls = (frac == '0) ? CLS_INF : CLS_NAN;
    else
      cls = CLS_NORM;
  end

endmodule

// File: rtl/sp_fmul_sig_mul.sv
module sp_fmul_sig_mul #(
  parameter int SIG_W = 24
) (
  input  logic [SIG_W-1:0]   sig_a,
  input  logic [SIG_W-1:0]   sig_b,
  output logic [2*SIG_W-1:0] prod
);

  localparam int PW = 2 * SIG_W;

  // full-width unsigned product; maps onto DSP cascades
  assign prod = PW'(sig_a) * PW'(sig_b);

endmodule

// File: rtl/sp_fmul_norm_round.sv
module sp_fmul_norm_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [2*(FRAC_W+1)-1:0] prod,
  input  logic signed [EXP_W+1:0] esum,
  output logic [FRAC_W-1:0]       frac_r,
  output logic signed [EXP_W+1:0] exp_r,
  output logic                    ovf_raw,
  output logic                    unf_raw
);

  localparam int SIG_W = FRAC_W + 1;
  localparam int PW    = 2 * SIG_W;
  localparam int ESW   = EXP_W + 2;
  localparam logic signed [ESW-1:0] EXP_TOP = ESW'((1 << EXP_W) - 2);
  localparam logic signed [ESW-1:0] EXP_LOW = ESW'(1);

  logic                    hi;
  logic [PW-2:0]           sl;
  logic [FRAC_W-1:0]       frac_t;
  logic                    guard_b, rnd_b, sticky_b, inc;
  logic [FRAC_W:0]         frac_sum;
  logic signed [ESW-1:0]   exp_n;

  // product lies in [1,4): at most one right shift (R3)
  assign hi     = prod[PW-1];
  assign sl     = hi ? prod[PW-2:0] : {prod[PW-3:0], 1'b0};
  assign exp_n  = esum + $signed(ESW'(hi));

  assign frac_t   = sl[PW-2 -: FRAC_W];
  assign guard_b  = sl[PW-2-FRAC_W];
  assign rnd_b    = sl[PW-3-FRAC_W];
  assign sticky_b = |sl[PW-4-FRAC_W:0];

  // nearest, ties to even (R4)
  assign inc      = guard_b & (rnd_b | sticky_b | frac_t[0]);
  assign frac_sum = {1'b0, frac_t} + (FRAC_W+1)'(inc);
  assign frac_r   = frac_sum[FRAC_W-1:0];
  assign exp_r    = exp_n + $signed(ESW'(frac_sum[FRAC_W]));

  // legal biased range after rounding (R5, R6)
  assign ovf_raw = (exp_r > EXP_TOP);
  assign unf_raw = (exp_r < EXP_LOW);

endmodule

// File: rtl/sp_fmul.sv
module sp_fmul
  import sp_fmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  ovf,
  output logic                  unf
);

  localparam int W     = EXP_W + FRAC_W + 1;
  localparam int SIG_W = FRAC_W + 1;
  localparam int PW    = 2 * SIG_W;
  localparam int ESW   = EXP_W + 2;
  localparam logic signed [ESW-1:0] BIAS_S = ESW'((1 << (EXP_W - 1)) - 1);

  // ---------------- stage 1: unpack, exponent, significand product
  logic [W-1:0]       ops  [2];
  logic               sgn  [2];
  logic [EXP_W-1:0]   bexp [2];
  logic [SIG_W-1:0]   sig  [2];
  fp_class_e          cls  [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < 2; i++) begin : g_unp
    sp_fmul_unpack #(
      .EXP_W (EXP_W),
      .FRAC_W(FRAC_W)
    ) u_unp (
      .word(ops[i]),
      .sign(sgn[i]),
      .bexp(bexp[i]),
      .sig (sig[i]),
      .cls (cls[i])
    );
  end

  logic [PW-1:0]          prod_c;
  logic signed [ESW-1:0]  esum_c;
  res_kind_e              kind_c;

  sp_fmul_sig_mul #(
    .SIG_W(SIG_W)
  ) u_mul (
    .sig_a(sig[0]),
    .sig_b(sig[1]),
    .prod (prod_c)
  );

  // both biased exponents added, one bias removed (R2)
  assign esum_c = $signed({2'b00, bexp[0]}) + $signed({2'b00, bexp[1]}) - BIAS_S;
  assign kind_c = pick_kind(cls[0], cls[1]);

  logic                   v1;
  logic                   s1_sign;
  logic signed [ESW-1:0]  s1_esum;
  logic [PW-1:0]          s1_prod;
  res_kind_e              s1_kind;

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_sign <= sgn[0] ^ sgn[1];   // R1
      s1_esum <= esum_c;
      s1_prod <= prod_c;
      s1_kind <= kind_c;
    end
  end

  // ---------------- stage 2: normalize, round, range check, pack
  logic [FRAC_W-1:0]      frac_r;
  logic signed [ESW-1:0]  exp_r;
  logic                   ovf_raw, unf_raw;

  sp_fmul_norm_round #(
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W)
  ) u_nr (
    .prod   (s1_prod),
    .esum   (s1_esum),
    .frac_r (frac_r),
    .exp_r  (exp_r),
    .ovf_raw(ovf_raw),
    .unf_raw(unf_raw)
  );

  logic [W-1:0] res_c;
  logic         ovf_c, unf_c;

  always_comb begin
    res_c = {s1_sign, exp_r[EXP_W-1:0], frac_r};
    ovf_c = 1'b0;
    unf_c = 1'b0;
    case (s1_kind)
      RK_NAN:  res_c = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
      RK_INF:  res_c = {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      RK_ZERO: res_c = {s1_sign, {(W-1){1'b0}}};
      default: begin
        if (ovf_raw) begin
          res_c = {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          ovf_c = 1'b1;
        end else if (unf_raw) begin
          res_c = {s1_sign, {(W-1){1'b0}}};
          unf_c = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        ovf <= ovf_c;
        unf <= unf_c;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (v1) result <= res_c;
  end

endmodule

// File: rtl/sp_fmul_chk.sv
module sp_fmul_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  ovf,
  input logic                  unf
);

  localparam int W = EXP_W + FRAC_W + 1;

  logic a_zero, b_zero, a_spec, b_spec, a_nan, b_nan;
  logic zero_case, nan_case, res_nan;

  assign a_zero = (op_a[W-2 -: EXP_W] == '0);
  assign b_zero = (op_b[W-2 -: EXP_W] == '0);
  assign a_spec = (op_a[W-2 -: EXP_W] == '1);
  assign b_spec = (op_b[W-2 -: EXP_W] == '1);
  assign a_nan  = a_spec && (op_a[FRAC_W-1:0] != '0);
  assign b_nan  = b_spec && (op_b[FRAC_W-1:0] != '0);

  assign zero_case = !a_spec && !b_spec && (a_zero || b_zero);
  assign nan_case  = a_nan || b_nan;
  assign res_nan   = (result[W-2 -: EXP_W] == '1) && (result[FRAC_W-1:0] != '0);

  logic [1:0] vq, sq, zq, nq;

  always_ff @(posedge clk) begin
    if (rst) begin
      vq <= '0; sq <= '0; zq <= '0; nq <= '0;
    end else begin
      vq <= {vq[0], in_valid};
      sq <= {sq[0], op_a[W-1] ^ op_b[W-1]};
      zq <= {zq[0], in_valid && zero_case};
      nq <= {nq[0], in_valid && nan_case};
    end
  end

  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == vq[1]);

  a_r1_sign: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !res_nan) |-> (result[W-1] == sq[1]));

  a_r5_overflow_inf: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ovf) |-> (!unf && result[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  a_r6_underflow_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && unf) |-> (result[W-2:0] == '0));

  a_r7_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (out_valid && zq[1]) |-> (result[W-2:0] == '0 && !ovf && !unf));

  a_r9_nan_quiet: assert property (@(posedge clk) disable iff (rst)
    (out_valid && nq[1]) |-> (res_nan && result[FRAC_W-1] && !ovf && !unf));

endmodule

bind sp_fmul sp_fmul_chk #(
  .EXP_W (EXP_W),
  .FRAC_W(FRAC_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op_a     (op_a),
  .op_b     (op_b),
  .out_valid(out_valid),
  .result   (result),
  .ovf      (ovf),
  .unf      (unf)
);

// File: tb/sp_fmul_tb_top.sv
module sp_fmul_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic        out_valid;
  logic [31:0] result;
  logic        ovf, unf;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  logic [31:0] q_a[$], q_b[$], q_res[$];
  logic        q_ovf[$], q_unf[$];
  int          q_cyc[$];
  string       q_tag[$];

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  sp_fmul dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result), .ovf(ovf), .unf(unf)
  );

  // magnitude of a normal single as an exact double
  function automatic real mag_of(input logic [31:0] x);
    logic [10:0] de;
    de = 11'(int'(x[30:23]) - 127 + 1023);
    return $bitstoreal({1'b0, de, x[22:0], 29'd0});
  endfunction

  // expected value from the requirements: exact product, rounded to 24 bits
  task automatic ref_mul(input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic o, output logic u);
    logic s, az, bz, ai, bi, an, bn;
    logic [63:0] bits;
    logic [22:0] keep;
    logic [28:0] rem;
    logic [23:0] kc;
    int e;
    s  = a[31] ^ b[31];
    az = (a[30:23] == 8'h00); bz = (b[30:23] == 8'h00);
    ai = (a[30:23] == 8'hFF) && (a[22:0] == 0);
    bi = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    o = 1'b0; u = 1'b0;
    if (an || bn || (ai && bz) || (az && bi)) r = 32'h7FC00000;
    else if (ai || bi) r = {s, 8'hFF, 23'd0};
    else if (az || bz) r = {s, 31'd0};
    else begin
      bits = $realtobits(mag_of(a) * mag_of(b));
      e    = int'(bits[62:52]) - 1023;
      keep = bits[51:29];
      rem  = bits[28:0];
      if (rem > 29'h1000_0000 || (rem == 29'h1000_0000 && keep[0])) begin
        kc   = {1'b0, keep} + 24'd1;
        keep = kc[22:0];
        if (kc[23]) e = e + 1;
      end
      e = e + 127;
      if (e > 254)    begin r = {s, 8'hFF, 23'd0}; o = 1'b1; end
      else if (e < 1) begin r = {s, 31'd0};        u = 1'b1; end
      else            r = {s, 8'(e), keep};
    end
  endtask

  // driver: one operation per call, expected item queued
  task automatic push_op(input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [31:0] r;
    logic o, u;
    ref_mul(a, b, r, o, u);
    op_a = a; op_b = b; in_valid = 1'b1;
    q_a.push_back(a); q_b.push_back(b); q_res.push_back(r);
    q_ovf.push_back(o); q_unf.push_back(u);
    q_cyc.push_back(cyc); q_tag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin : mon
    logic [31:0] ea, eb, er;
    logic eo, eu;
    int ec;
    string tg;
    if (!rst && out_valid) begin
      if (q_res.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R10: out_valid actual 1 with nothing pending, expected 0");
      end else begin
        ea = q_a.pop_front(); eb = q_b.pop_front(); er = q_res.pop_front();
        eo = q_ovf.pop_front(); eu = q_unf.pop_front();
        ec = q_cyc.pop_front(); tg = q_tag.pop_front();
        n_checks++;
        if (result !== er || ovf !== eo || unf !== eu) begin
          n_fail++;
          $display("FAIL %s: %h * %h actual %h ovf %b unf %b, expected %h ovf %b unf %b",
                   tg, ea, eb, result, ovf, unf, er, eo, eu);
        end
        n_checks++;
        if (cyc - ec != 2) begin
          n_fail++;
          $display("FAIL R10: latency actual %0d, expected 2", cyc - ec);
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run actual hung, expected completion");
    summary();
    $finish;
  end

  initial begin : main
    rst = 1'b1; in_valid = 1'b1; op_a = 32'h3F800000; op_b = 32'h3F800000;
    idle(4);
    // R11: reset clears outputs even with operands presented
    n_checks++;
    if (out_valid !== 1'b0 || ovf !== 1'b0 || unf !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: reset outputs actual %b%b%b, expected 000", out_valid, ovf, unf);
    end
    in_valid = 1'b0; rst = 1'b0;
    idle(3);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: out_valid after reset actual %b, expected 0", out_valid);
    end

    // R2 worked example
    push_op(32'h3F000000, 32'hBEE00000, "R2");
    push_op(32'h40A00000, 32'h3F400000, "R2");
    // R3 normalization shift
    push_op(32'h3FC00000, 32'h3FC00000, "R3");
    push_op(32'h3FFFFFFF, 32'h3FFFFFFF, "R3");
    // R4 rounding ties and near ties
    push_op(32'h3F800001, 32'h3FC00000, "R4");
    push_op(32'h3F800003, 32'h3FC00000, "R4");
    push_op(32'h3F800001, 32'h3F800001, "R4");
    push_op(32'h3FFFFFFF, 32'h3F800001, "R4");
    idle(1);
    // R1 sign combinations
    push_op(32'hC0400000, 32'hC0000000, "R1");
    push_op(32'h40400000, 32'hC0000000, "R1");
    // R5 overflow and last legal exponent
    push_op(32'h7F000000, 32'h40000000, "R5");
    push_op(32'hFF000000, 32'h7F000000, "R5");
    push_op(32'h7F7FFFFF, 32'h3F800000, "R5");
    // R6 underflow and first legal exponent
    push_op(32'h00800000, 32'h3F000000, "R6");
    push_op(32'h80800000, 32'h3F000000, "R6");
    push_op(32'h00800000, 32'h3F800000, "R6");
    // R7 zeros, subnormal as zero
    push_op(32'h00000000, 32'hC0000000, "R7");
    push_op(32'h00000001, 32'h3F800000, "R7");
    push_op(32'h80000000, 32'h80000000, "R7");
    // R8 infinities
    push_op(32'h7F800000, 32'hC0000000, "R8");
    push_op(32'h7F800000, 32'h7F800000, "R8");
    // R9 NaN cases
    push_op(32'h7F800000, 32'h00000000, "R9");
    push_op(32'h7FC00001, 32'h3F800000, "R9");
    push_op(32'hFF800000, 32'h80000000, "R9");
    idle(2);

    // randomized sweep with gaps (R4 ordinary range, R1 full range)
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if (i % 4 != 0) begin
        a[30:23] = 8'(96 + $urandom_range(0, 60));
        b[30:23] = 8'(96 + $urandom_range(0, 60));
      end
      push_op(a, b, (i % 4 == 0) ? "R1" : "R4");
      if (i % 7 == 0) idle(1);
    end

    idle(6);
    // R10: every operation produced exactly one result
    n_checks++;
    if (q_res.size() != 0) begin
      n_fail++;
      $display("FAIL R10: pending results actual %0d, expected 0", q_res.size());
    end
    summary();
    $finish;
  end

endmodule